// File: doc/BRIEF.md
# Reference Clock Selection Controller

This block decides which of three reference clocks drives a downstream clock synthesis loop. The three inputs are a primary A, a secondary B and a fallback F. When no usable reference remains, the block tells the loop to freeze its frequency instead. Loss-of-signal and frequency-offset alarms arrive from detectors outside the block. The block combines them into a failure verdict for each input. Its outputs are one-hot active flags plus a hold flag.

In automatic mode, the choice follows a fixed priority: A first, then B, then F. A revert control picks between two behaviours. In one, the block always returns to the best healthy input. In the other, it stays on a healthy input even after a better one recovers.

In manual mode, a 2-bit select names the input directly. Only loss of signal on the named input causes a hold.

Every pin is resynchronised through a two-flop stage before the decision register. A one-cycle pulse marks each change of the outputs.

Top module: `refclk_selector`

## Requirements
- R1: After the active-low synchronous reset, act_a is 1, act_b, act_f and hold are 0, and sel_evt is 0.
- R2: Input A counts as failing when los_a is 1, or when fos_a is 1 while los_f is 0. B follows the same rule with los_b and fos_b. F fails only when los_f is 1.
- R3: In automatic mode (auto_sel=1), the priority order is A, then B, then F. When all three inputs fail, hold goes to 1.
- R4: With revert_en=1 in automatic mode, the active input is always the highest-priority input that is not failing.
- R5: With revert_en=0 in automatic mode, the active input is kept while it is not failing. When it fails, the block moves to the highest-priority healthy input.
- R6: On entry to hold, the previously active flag stays at 1. Leaving hold moves to the highest-priority healthy input and clears hold.
- R7: With auto_sel=0, man_sel picks the input with this encoding: 2'b00 picks A, 2'b01 picks B, 2'b10 picks F, and 2'b11 forces hold while keeping the previous flag.
- R8: In manual mode, los on the selected input gives hold=1 with that input's flag set. Frequency-offset alarms do not affect selection or hold.
- R9: While auto_sel=1, man_sel has no effect on the outputs.
- R10: sel_evt is 1 for exactly one cycle, in the first cycle in which any of act_a, act_b, act_f or hold shows a new value.
- R11: An input change that is set up before rising edge k appears on the outputs after rising edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| los_a | input | 1 | Loss-of-signal alarm, input A |
| los_b | input | 1 | Loss-of-signal alarm, input B |
| los_f | input | 1 | Loss-of-signal alarm, fallback F |
| fos_a | input | 1 | Frequency-offset alarm, input A |
| fos_b | input | 1 | Frequency-offset alarm, input B |
| auto_sel | input | 1 | 1 = automatic priority switching, 0 = manual |
| revert_en | input | 1 | 1 = revertive, 0 = non-revertive (automatic mode) |
| man_sel | input | 2 | Manual choice: 00 A, 01 B, 10 F, 11 hold |
| act_a | output | 1 | Input A is (or was, when in hold) the active reference |
| act_b | output | 1 | Input B active flag |
| act_f | output | 1 | Fallback F active flag |
| hold | output | 1 | Loop frequency hold |
| sel_evt | output | 1 | One-cycle pulse on any change of the flags or hold |

## Verification
Two functions can meet in one decision cycle.

The first case is leaving hold. It clears hold and also chooses a new input in the same cycle. The bench provokes this by releasing los_f alone while A and B are still failing. The bench expects act_f together with hold=0, and one single sel_evt pulse.

The second case is a change of los_f. It shifts which frequency alarms count, so it can trigger a revertive return and a failure in the same step. The bench provokes this by raising los_f while fos_a is held high. The bench expects the return to A.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_F = 2'd2
    } ref_sel_e;

    typedef struct packed {
        ref_sel_e sel;
        logic     hold;
        logic     evt;
    } sel_state_t;

    localparam logic [1:0] MAN_A    = 2'b00;
    localparam logic [1:0] MAN_B    = 2'b01;
    localparam logic [1:0] MAN_F    = 2'b10;
    localparam logic [1:0] MAN_HOLD = 2'b11;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = din;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/refsel_fail_eval.sv
module refsel_fail_eval (
    input  logic los_a,
    input  logic los_b,
    input  logic los_f,
    input  logic fos_a,
    input  logic fos_b,
    output logic fail_a,
    output logic fail_b,
    output logic fail_f
);

    // frequency offset only disqualifies a primary while the fallback is present
    always_comb begin
        fail_a = los_a | (fos_a & ~los_f);
        fail_b = los_b | (fos_b & ~los_f);
        fail_f = los_f;
    end

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fail_a,
    input  logic       fail_b,
    input  logic       fail_f,
    input  logic       los_a,
    input  logic       los_b,
    input  logic       los_f,
    input  logic       auto_s,
    input  logic       revert_s,
    input  logic [1:0] man_s,
    output ref_sel_e   sel_q,
    output logic       hold_q,
    output logic       evt_q
);

    sel_state_t st_d, st_q;
    logic       cur_fail;
    logic       all_fail;
    ref_sel_e   best_sel;

    always_comb begin
        unique case (st_q.sel)
            SEL_A:   cur_fail = fail_a;
            SEL_B:   cur_fail = fail_b;
            default: cur_fail = fail_f;
        endcase
        all_fail = fail_a & fail_b & fail_f;
        if (!fail_a)      best_sel = SEL_A;
        else if (!fail_b) best_sel = SEL_B;
        else              best_sel = SEL_F;
    end

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (auto_s) begin
            if (all_fail) begin
                st_d.hold = 1'b1;
            end else if (revert_s || st_q.hold || cur_fail) begin
                st_d.sel  = best_sel;
                st_d.hold = 1'b0;
            end
        end else begin
            unique case (man_s)
                MAN_A: begin st_d.sel = SEL_A; st_d.hold = los_a; end
                MAN_B: begin st_d.sel = SEL_B; st_d.hold = los_b; end
                MAN_F: begin st_d.sel = SEL_F; st_d.hold = los_f; end
                default: st_d.hold = 1'b1;
            endcase
        end
        st_d.evt = (st_d.sel != st_q.sel) || (st_d.hold != st_q.hold);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sel: SEL_A, hold: 1'b0, evt: 1'b0};
        else        st_q <= st_d;
    end

    assign sel_q  = st_q.sel;
    assign hold_q = st_q.hold;
    assign evt_q  = st_q.evt;

    // R3
    all_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && fail_a && fail_b && fail_f) |=> hold_q);

    // R4
    revert_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && revert_s && !fail_a) |=> (sel_q == SEL_A && !hold_q));

    // R5
    nonrev_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_s && !revert_s && !hold_q && !cur_fail) |=> ($stable(sel_q) && !hold_q));

    // R6
    hold_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_q) && $past(auto_s)) |-> $stable(sel_q));

    // R8
    man_b_no_fos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_s && man_s == MAN_B && !los_b) |=> (sel_q == SEL_B && !hold_q));

    // R10
    evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q) || hold_q != $past(hold_q)) |-> evt_q);

endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import refsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       los_a,
    input  logic       los_b,
    input  logic       los_f,
    input  logic       fos_a,
    input  logic       fos_b,
    input  logic       auto_sel,
    input  logic       revert_en,
    input  logic [1:0] man_sel,
    output logic       act_a,
    output logic       act_b,
    output logic       act_f,
    output logic       hold,
    output logic       sel_evt
);

    localparam int PIN_W = 9;

    logic [PIN_W-1:0] raw_pins, sync_pins;
    logic       s_los_a, s_los_b, s_los_f, s_fos_a, s_fos_b;
    logic       s_auto, s_revert;
    logic [1:0] s_man;
    logic       fail_a, fail_b, fail_f;
    ref_sel_e   sel_q;

    assign raw_pins = {los_a, los_b, los_f, fos_a, fos_b, auto_sel, revert_en, man_sel};

    refsel_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_pins),
        .dout (sync_pins)
    );

    assign {s_los_a, s_los_b, s_los_f, s_fos_a, s_fos_b, s_auto, s_revert, s_man} = sync_pins;

    refsel_fail_eval i_fail (
        .los_a (s_los_a),
        .los_b (s_los_b),
        .los_f (s_los_f),
        .fos_a (s_fos_a),
        .fos_b (s_fos_b),
        .fail_a(fail_a),
        .fail_b(fail_b),
        .fail_f(fail_f)
    );

    refsel_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail_a  (fail_a),
        .fail_b  (fail_b),
        .fail_f  (fail_f),
        .los_a   (s_los_a),
        .los_b   (s_los_b),
        .los_f   (s_los_f),
        .auto_s  (s_auto),
        .revert_s(s_revert),
        .man_s   (s_man),
        .sel_q   (sel_q),
        .hold_q  (hold),
        .evt_q   (sel_evt)
    );

    assign act_a = (sel_q == SEL_A);
    assign act_b = (sel_q == SEL_B);
    assign act_f = (sel_q == SEL_F);

    // R1
    act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({act_a, act_b, act_f}) == 1);

endmodule

// File: tb/test_refclk_selector.sv
module test_refclk_selector;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic los_a = 0, los_b = 0, los_f = 0, fos_a = 0, fos_b = 0;
    logic auto_sel = 1'b1, revert_en = 1'b0;
    logic [1:0] man_sel = 2'b00;
    logic act_a, act_b, act_f, hold, sel_evt;

    always #4 clk = ~clk;

    refclk_selector i_refclk_selector (
        .clk(clk), .rst_n(rst_n),
        .los_a(los_a), .los_b(los_b), .los_f(los_f),
        .fos_a(fos_a), .fos_b(fos_b),
        .auto_sel(auto_sel), .revert_en(revert_en), .man_sel(man_sel),
        .act_a(act_a), .act_b(act_b), .act_f(act_f),
        .hold(hold), .sel_evt(sel_evt)
    );

    typedef struct {
        int    due;
        logic  a, b, f, h, e;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   m_sel = 0;
    logic m_hold = 1'b0;

    always @(posedge clk) cyc++;

    task automatic compare(input string req, input logic a, b, f, h, e);
        n_chk++;
        if ({act_a, act_b, act_f, hold, sel_evt} !== {a, b, f, h, e}) begin
            n_fail++;
            $display("FAIL %s: got a=%0b b=%0b f=%0b hold=%0b evt=%0b, exp a=%0b b=%0b f=%0b hold=%0b evt=%0b",
                     req, act_a, act_b, act_f, hold, sel_evt, a, b, f, h, e);
        end
    endtask

    // monitor: pops items when due and compares them
    initial forever begin
        @(negedge clk);
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            it = q.pop_front();
            compare(it.req, it.a, it.b, it.f, it.h, it.e);
        end
    end

    // driver: inputs already applied at this negedge; predict and queue
    task automatic step(input string req);
        logic fa, fb, ff, cf;
        int   ns;
        logic nh, ch;
        exp_t it;
        fa = los_a | (fos_a & ~los_f);
        fb = los_b | (fos_b & ~los_f);
        ff = los_f;
        ns = m_sel;
        nh = m_hold;
        cf = (m_sel == 0) ? fa : (m_sel == 1) ? fb : ff;
        if (auto_sel) begin
            if (fa && fb && ff) nh = 1'b1;
            else if (revert_en || m_hold || cf) begin
                ns = !fa ? 0 : (!fb ? 1 : 2);
                nh = 1'b0;
            end
        end else begin
            case (man_sel)
                2'b00: begin ns = 0; nh = los_a; end
                2'b01: begin ns = 1; nh = los_b; end
                2'b10: begin ns = 2; nh = los_f; end
                default: nh = 1'b1;
            endcase
        end
        ch = (ns != m_sel) || (nh != m_hold);
        m_sel = ns;
        m_hold = nh;
        // R11: outputs update after the third rising edge
        it.due = cyc + 3; it.a = (ns == 0); it.b = (ns == 1); it.f = (ns == 2);
        it.h = nh; it.e = ch; it.req = req;
        q.push_back(it);
        it.due = cyc + 4; it.e = 1'b0; it.req = {req, "/R10"};
        q.push_back(it);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        compare("R1", 1, 0, 0, 0, 0);

        los_a = 1;                   step("R5 leave failed A");
        los_a = 0;                   step("R5 stay on B");
        revert_en = 1;               step("R4 return to A");
        fos_a = 1;                   step("R2 fos_a counts");
        los_f = 1;                   step("R2 fos ignored without F");
        los_a = 1; fos_b = 1;        step("R2 R3 B despite fos_b");
        los_b = 1;                   step("R3 R6 all fail hold");
        los_f = 0;                   step("R6 exit hold to F");
        los_a = 0; los_b = 0; fos_a = 0; fos_b = 0; step("R4 back to A");
        revert_en = 0; los_a = 1; los_b = 1; step("R3 F last");
        los_a = 0;                   step("R5 stay on F");
        los_b = 0;                   step("R5 still F");
        auto_sel = 0; man_sel = 2'b01; step("R7 manual B");
        fos_b = 1;                   step("R8 fos no effect");
        los_b = 1;                   step("R8 los forces hold");
        man_sel = 2'b11; los_b = 0;  step("R7 forced hold");
        man_sel = 2'b00;             step("R7 manual A");
        los_f = 1; man_sel = 2'b10;  step("R8 F lost");
        los_f = 0; fos_b = 0; auto_sel = 1; step("R9 back to auto");
        man_sel = 2'b01;             step("R9 man_sel ignored");
        man_sel = 2'b11;             step("R9 man_sel 11 ignored");
        revert_en = 1; los_a = 1;    step("R4 go to B");
        los_a = 0;                   step("R4 revert A");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule